// File: doc/BRIEF.md
# CPU Clock Mode Sequencer

This block decides which clock drives a microcontroller core and at what rate. Software writes a mode code into a 32-bit control word. The sequencer supports five modes. It can pass the oscillator through unchanged. It can route one of two PLL-derived clocks: the normal multiplied clock, or a variant that skips the first divider stage. It can drop the core to one tick in every 128 oscillator cycles. Finally, it has a deep-slow state that also gates most peripheral clock enables. The analog PLL lies outside the block and is seen only through its lock input. The downstream glitch-free clock multiplexer is also outside, and takes its select from this block.

The sequencer enforces the legal mode graph. The PLL modes can be reached only from the oscillator-direct mode and can leave only back to it. A PLL request needs a good lock and an idle interrupt/DMA system. After an accepted request, the PLL-active status waits for a fixed divider-synchronisation interval, while the slow modes take effect on the next cycle. The PLL multiplier and I/O prescaler settings can be written only while the oscillator clock is direct. Every refused request raises a sticky error flag, which clears when software reads the status.

Top module: `clkmode_seq`

## Requirements
- R1: After reset the mode readback is 0x1 (oscillator-direct). In that state clk_sel is 0, pll_active and mode_err are 0, every periph_en bit is 1, and cpu_clk_en is high on every cycle.
- R2: A mode write is a bus_wr at bus_addr 0 with bus_full high, and the code sits in bus_wdata[3:0] with the upper bits ignored. The codes are 0x1 oscillator-direct, 0x3 PLL, 0x7 PLL bypass, 0x5 slow and 0x9 deep-slow. If bus_full is low, the mode write has no effect.
- R3: A PLL code is accepted only in the oscillator-direct mode. From a PLL mode only code 0x1 is accepted. While a PLL switch is still synchronising, every mode write is refused. A refused write leaves the mode unchanged and sets mode_err.
- R4: Writes to bus_addr 1 (multiplier, bus_wdata[PMF_W-1:0]) and bus_addr 2 (prescaler, bus_wdata[IOP_W-1:0]) update pmf_q and iop_q only while the mode is oscillator-direct with no switch pending. At all other times they are ignored.
- R5: lock_sts follows pll_lock one cycle later. A PLL request made while lock_sts is 0 is refused and sets mode_err.
- R6: Once a PLL request is accepted, the readback shows the requested code. pll_active and the PLL clk_sel value (1 for PLL, 2 for bypass) appear SYNC_CYC cycles after the accepting edge, counting only cycles with lock_sts high. A write of 0x1 from a PLL mode clears pll_active and sets clk_sel to 0 on the next cycle.
- R7: In slow mode (clk_sel 3) and deep-slow mode (clk_sel 4), cpu_clk_en is high for one cycle in every 2^DIV_LOG2 (128 by default). Switching between the slow modes and oscillator-direct takes effect on the cycle after the write.
- R8: In deep-slow mode periph_en equals DEEP_KEEP (0x03 by default). In every other mode all periph_en bits are 1.
- R9: A valid mode write made while irq_dma_off is 0 is refused and sets mode_err.
- R10: A mode write with an unlisted code changes nothing and does not set mode_err.
- R11: mode_err stays set until a cycle with stat_rd high clears it. If a refusal happens in the same cycle as stat_rd, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 mode, 1 multiplier, 2 prescaler |
| bus_wdata | input | 32 | Write data |
| bus_full | input | 1 | Write is a full 32-bit access |
| stat_rd | input | 1 | Status read strobe; clears mode_err |
| pll_lock | input | 1 | Lock indication from the PLL |
| irq_dma_off | input | 1 | 1 when interrupts and DMA are disabled |
| mode_rd | output | 4 | Current accepted mode code |
| lock_sts | output | 1 | Registered PLL lock status |
| pll_active | output | 1 | PLL mode fully synchronised and running |
| mode_err | output | 1 | Sticky refused-request flag |
| pmf_q | output | PMF_W | PLL multiplication factor setting |
| iop_q | output | IOP_W | I/O prescaler setting |
| clk_sel | output | 3 | Clock source select: 0 osc, 1 PLL, 2 PLL bypass, 3 slow, 4 deep-slow |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_en | output | PERIPH_N | Peripheral clock enables |

## Verification
A wrong internal state is visible at mode_rd on the first cycle after the offending write. Examples are a PLL mode entered from a slow mode, or a transition left in place after a refusal. The same cycle also shows whether mode_err rose. A sync counter that is off by one moves the rise of pll_active and clk_sel by one cycle, so the bench samples both the cycle before and the cycle of the expected switch. A faulty slow divider or peripheral mask shows within one 128-cycle window on cpu_clk_en or at once on periph_en.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   typedef enum logic [2:0] {
      ST_FAST, ST_SYNC, ST_PLL, ST_PLL2, ST_SLOW, ST_DEEP
   } cm_state_e;

   typedef enum logic [2:0] {
      REQ_NONE, REQ_FAST, REQ_PLL, REQ_PLL2, REQ_SLOW, REQ_DEEP
   } cm_req_e;

   typedef enum logic [2:0] {
      SEL_OSC = 3'd0, SEL_PLL = 3'd1, SEL_PLL2 = 3'd2, SEL_SLOW = 3'd3, SEL_DEEP = 3'd4
   } cm_sel_e;

   localparam logic [3:0] CODE_FAST = 4'h1;
   localparam logic [3:0] CODE_PLL  = 4'h3;
   localparam logic [3:0] CODE_PLL2 = 4'h7;
   localparam logic [3:0] CODE_SLOW = 4'h5;
   localparam logic [3:0] CODE_DEEP = 4'h9;

endpackage

// File: rtl/clkmode_dec.sv
module clkmode_dec
   import clkmode_pkg::*;
(
   input  logic       strobe,
   input  logic [3:0] code,
   output cm_req_e    req
);
   always_comb begin
      req = REQ_NONE;
      if (strobe) begin
         case (code)
            CODE_FAST: req = REQ_FAST;
            CODE_PLL:  req = REQ_PLL;
            CODE_PLL2: req = REQ_PLL2;
            CODE_SLOW: req = REQ_SLOW;
            CODE_DEEP: req = REQ_DEEP;
            default:   req = REQ_NONE;
         endcase
      end
   end
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
   import clkmode_pkg::*;
#(
   parameter int SYNC_CYC = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  cm_req_e   req,
   input  logic      lock_ok,
   input  logic      irq_off,
   input  logic      err_rd,
   output cm_state_e state_q,
   output logic      tgt_pll2_q,
   output logic      err_q
);
   localparam int CNT_W = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYC - 1);

   cm_state_e        nxt;
   logic             nxt_pll2;
   logic             reject;
   logic             sync_done;
   logic [CNT_W-1:0] cnt_q;

   assign sync_done = (state_q == ST_SYNC) && lock_ok && (cnt_q == CNT_LAST);

   always_comb begin
      nxt      = state_q;
      nxt_pll2 = tgt_pll2_q;
      reject   = 1'b0;
      if (state_q == ST_SYNC) begin
         if (sync_done) nxt = tgt_pll2_q ? ST_PLL2 : ST_PLL;
         if (req != REQ_NONE) reject = 1'b1;
      end else if (req != REQ_NONE) begin
         if (!irq_off) begin
            reject = 1'b1;
         end else begin
            case (state_q)
               ST_FAST: begin
                  case (req)
                     REQ_PLL, REQ_PLL2: begin
                        if (lock_ok) begin
                           nxt      = ST_SYNC;
                           nxt_pll2 = (req == REQ_PLL2);
                        end else begin
                           reject = 1'b1;
                        end
                     end
                     REQ_SLOW: nxt = ST_SLOW;
                     REQ_DEEP: nxt = ST_DEEP;
                     default:  nxt = ST_FAST;
                  endcase
               end
               ST_SLOW, ST_DEEP: begin
                  case (req)
                     REQ_PLL, REQ_PLL2: reject = 1'b1;
                     REQ_SLOW: nxt = ST_SLOW;
                     REQ_DEEP: nxt = ST_DEEP;
                     default:  nxt = ST_FAST;
                  endcase
               end
               default: begin
                  if (req == REQ_FAST) nxt = ST_FAST;
                  else reject = 1'b1;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_FAST;
         tgt_pll2_q <= 1'b0;
         cnt_q      <= '0;
         err_q      <= 1'b0;
      end else begin
         state_q    <= nxt;
         tgt_pll2_q <= nxt_pll2;
         if (state_q != ST_SYNC)      cnt_q <= '0;
         else if (lock_ok && !sync_done) cnt_q <= cnt_q + 1'b1;
         if (reject)      err_q <= 1'b1;
         else if (err_rd) err_q <= 1'b0;
      end
   end
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
   parameter int DIV_LOG2 = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_mode,
   output logic clk_en
);
   logic [DIV_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign clk_en = !slow_mode || (&pre_q);
endmodule

// File: rtl/clkmode_cfg.sv
module clkmode_cfg #(
   parameter int PMF_W = 6,
   parameter int IOP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             allow,
   input  logic             wr_pmf,
   input  logic             wr_iop,
   input  logic [31:0]      wdata,
   output logic [PMF_W-1:0] pmf_q,
   output logic [IOP_W-1:0] iop_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmf_q <= '0;
         iop_q <= '0;
      end else if (allow) begin
         if (wr_pmf) pmf_q <= wdata[PMF_W-1:0];
         if (wr_iop) iop_q <= wdata[IOP_W-1:0];
      end
   end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
   import clkmode_pkg::*;
#(
   parameter int                PMF_W     = 6,
   parameter int                IOP_W     = 4,
   parameter int                SYNC_CYC  = 8,
   parameter int                DIV_LOG2  = 7,
   parameter int                PERIPH_N  = 8,
   parameter logic [PERIPH_N-1:0] DEEP_KEEP = PERIPH_N'(3)
) (
   input  logic                clk_osc,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [1:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic                bus_full,
   input  logic                stat_rd,
   input  logic                pll_lock,
   input  logic                irq_dma_off,
   output logic [3:0]          mode_rd,
   output logic                lock_sts,
   output logic                pll_active,
   output logic                mode_err,
   output logic [PMF_W-1:0]    pmf_q,
   output logic [IOP_W-1:0]    iop_q,
   output logic [2:0]          clk_sel,
   output logic                cpu_clk_en,
   output logic [PERIPH_N-1:0] periph_en
);
   if (PMF_W < 1 || PMF_W > 32) begin : g_bad_pmf
      $error("PMF_W out of range");
   end
   if (IOP_W < 1 || IOP_W > 32) begin : g_bad_iop
      $error("IOP_W out of range");
   end
   if (SYNC_CYC < 2) begin : g_bad_sync
      $error("SYNC_CYC must be at least 2");
   end
   if (DIV_LOG2 < 1) begin : g_bad_div
      $error("DIV_LOG2 must be at least 1");
   end

   cm_req_e   req;
   cm_state_e state_q;
   logic      tgt_pll2_q;
   logic      lock_q;
   logic      is_slow;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= pll_lock;
   end
   assign lock_sts = lock_q;

   clkmode_dec u_dec (
      .strobe (bus_wr && bus_full && (bus_addr == 2'd0)),
      .code   (bus_wdata[3:0]),
      .req    (req)
   );

   clkmode_fsm #(.SYNC_CYC(SYNC_CYC)) u_fsm (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .req        (req),
      .lock_ok    (lock_q),
      .irq_off    (irq_dma_off),
      .err_rd     (stat_rd),
      .state_q    (state_q),
      .tgt_pll2_q (tgt_pll2_q),
      .err_q      (mode_err)
   );

   clkmode_cfg #(.PMF_W(PMF_W), .IOP_W(IOP_W)) u_cfg (
      .clk    (clk_osc),
      .rst_n  (rst_n),
      .allow  (state_q == ST_FAST),
      .wr_pmf (bus_wr && (bus_addr == 2'd1)),
      .wr_iop (bus_wr && (bus_addr == 2'd2)),
      .wdata  (bus_wdata),
      .pmf_q  (pmf_q),
      .iop_q  (iop_q)
   );

   assign is_slow = (state_q == ST_SLOW) || (state_q == ST_DEEP);

   clkmode_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk       (clk_osc),
      .rst_n     (rst_n),
      .slow_mode (is_slow),
      .clk_en    (cpu_clk_en)
   );

   always_comb begin
      case (state_q)
         ST_SYNC: begin mode_rd = tgt_pll2_q ? CODE_PLL2 : CODE_PLL; clk_sel = SEL_OSC;  end
         ST_PLL:  begin mode_rd = CODE_PLL;  clk_sel = SEL_PLL;  end
         ST_PLL2: begin mode_rd = CODE_PLL2; clk_sel = SEL_PLL2; end
         ST_SLOW: begin mode_rd = CODE_SLOW; clk_sel = SEL_SLOW; end
         ST_DEEP: begin mode_rd = CODE_DEEP; clk_sel = SEL_DEEP; end
         default: begin mode_rd = CODE_FAST; clk_sel = SEL_OSC;  end
      endcase
   end

   assign pll_active = (state_q == ST_PLL) || (state_q == ST_PLL2);

   for (genvar i = 0; i < PERIPH_N; i++) begin : g_pen
      assign periph_en[i] = (state_q == ST_DEEP) ? DEEP_KEEP[i] : 1'b1;
   end
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk #(
   parameter int                  PMF_W     = 6,
   parameter int                  IOP_W     = 4,
   parameter int                  PERIPH_N  = 8,
   parameter logic [PERIPH_N-1:0] DEEP_KEEP = PERIPH_N'(3)
) (
   input logic                clk_osc,
   input logic                rst_n,
   input logic                irq_dma_off,
   input logic [3:0]          mode_rd,
   input logic                pll_active,
   input logic [PMF_W-1:0]    pmf_q,
   input logic [IOP_W-1:0]    iop_q,
   input logic [2:0]          clk_sel,
   input logic                cpu_clk_en,
   input logic [PERIPH_N-1:0] periph_en
);
   assert_pll_entry_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ((mode_rd != $past(mode_rd)) && (mode_rd == 4'h3 || mode_rd == 4'h7)) |-> ($past(mode_rd) == 4'h1));

   assert_pll_exit_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (($past(mode_rd) == 4'h3 || $past(mode_rd) == 4'h7) && (mode_rd != $past(mode_rd))) |-> (mode_rd == 4'h1));

   assert_cfg_frozen_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ($past(mode_rd) != 4'h1) |-> ($stable(pmf_q) && $stable(iop_q)));

   assert_sync_wait_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (($past(mode_rd) == 4'h1) && (mode_rd == 4'h3 || mode_rd == 4'h7)) |-> (!pll_active && clk_sel == 3'd0));

   assert_slow_gap_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ((mode_rd == 4'h5) && cpu_clk_en) |=> (!cpu_clk_en || mode_rd != 4'h5));

   assert_deep_mask_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (mode_rd == 4'h9) |-> (periph_en == DEEP_KEEP));

   assert_irq_block_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !$past(irq_dma_off) |-> $stable(mode_rd));
endmodule

bind clkmode_seq clkmode_chk #(
   .PMF_W(PMF_W), .IOP_W(IOP_W), .PERIPH_N(PERIPH_N), .DEEP_KEEP(DEEP_KEEP)
) u_chk (.*);

// File: tb/tb_clkmode_seq.sv
`timescale 1ns/1ps
module tb_clkmode_seq;
   logic        clk_osc = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic        bus_full = 1'b0;
   logic        stat_rd = 1'b0;
   logic        pll_lock = 1'b1;
   logic        irq_dma_off = 1'b1;
   logic [3:0]  mode_rd;
   logic        lock_sts, pll_active, mode_err, cpu_clk_en;
   logic [5:0]  pmf_q;
   logic [3:0]  iop_q;
   logic [2:0]  clk_sel;
   logic [7:0]  periph_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk_osc = ~clk_osc;

   clkmode_seq dut (.*);

   // {code[7:0], full, irq_off, exp_mode[3:0], exp_err}
   localparam int NV = 9;
   localparam logic [14:0] VEC [NV] = '{
      {8'h05, 1'b1, 1'b1, 4'h5, 1'b0},   // R7 enter slow
      {8'h03, 1'b1, 1'b1, 4'h5, 1'b1},   // R3 PLL from slow refused
      {8'h09, 1'b1, 1'b1, 4'h9, 1'b0},   // R8 slow to deep
      {8'h01, 1'b1, 1'b1, 4'h1, 1'b0},   // R7 back to fast
      {8'h0F, 1'b1, 1'b1, 4'h1, 1'b0},   // R10 unlisted code
      {8'h05, 1'b0, 1'b1, 4'h1, 1'b0},   // R2 partial access ignored
      {8'h05, 1'b1, 1'b0, 4'h1, 1'b1},   // R9 irq/dma live
      {8'hF5, 1'b1, 1'b1, 4'h5, 1'b0},   // R2 upper bits ignored
      {8'h01, 1'b1, 1'b1, 4'h1, 1'b0}    // R2 fast code
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic f, input logic irq);
      @(negedge clk_osc);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_full = f; irq_dma_off = irq;
      @(negedge clk_osc);
      bus_wr = 1'b0; bus_full = 1'b0; irq_dma_off = 1'b1;
   endtask

   task automatic clr_err();
      @(negedge clk_osc); stat_rd = 1'b1;
      @(negedge clk_osc); stat_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk_osc);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk_osc);
      rst_n = 1'b1;
      @(negedge clk_osc);
      // R1 reset state
      chk("R1 mode", mode_rd, 32'h1);
      chk("R1 clk_sel", clk_sel, 32'd0);
      chk("R1 pll_active", pll_active, 32'd0);
      chk("R1 err", mode_err, 32'd0);
      chk("R1 periph", periph_en, 32'hFF);
      chk("R1 cpu_clk_en", cpu_clk_en, 32'd1);

      for (int i = 0; i < NV; i++) begin
         wr(2'd0, {24'd0, VEC[i][14:7]}, VEC[i][6], VEC[i][5]);
         chk($sformatf("table[%0d] mode", i), mode_rd, {28'd0, VEC[i][4:1]});
         chk($sformatf("table[%0d] err", i), mode_err, {31'd0, VEC[i][0]});
         clr_err();
      end

      // R5 lock gating
      pll_lock = 1'b0;
      repeat (2) @(negedge clk_osc);
      chk("R5 lock_sts low", lock_sts, 32'd0);
      wr(2'd0, 32'h3, 1'b1, 1'b1);
      chk("R5 refused mode", mode_rd, 32'h1);
      chk("R5 refused err", mode_err, 32'd1);
      clr_err();
      pll_lock = 1'b1;
      repeat (2) @(negedge clk_osc);
      chk("R5 lock_sts high", lock_sts, 32'd1);

      // R4 config writable in fast
      wr(2'd1, 32'h2A, 1'b1, 1'b1);
      wr(2'd2, 32'h5, 1'b0, 1'b1);
      chk("R4 pmf fast", pmf_q, 32'h2A);
      chk("R4 iop fast", iop_q, 32'h5);

      // R6 PLL entry timing
      wr(2'd0, 32'h3, 1'b1, 1'b1);
      chk("R6 code shown", mode_rd, 32'h3);
      chk("R6 not yet active", pll_active, 32'd0);
      repeat (7) @(negedge clk_osc);
      chk("R6 active one early", pll_active, 32'd0);
      @(negedge clk_osc);
      chk("R6 active", pll_active, 32'd1);
      chk("R6 clk_sel pll", clk_sel, 32'd1);

      // R4 config frozen in PLL
      wr(2'd1, 32'h11, 1'b1, 1'b1);
      chk("R4 pmf frozen", pmf_q, 32'h2A);

      // R3 PLL to slow refused
      wr(2'd0, 32'h5, 1'b1, 1'b1);
      chk("R3 pll->slow mode", mode_rd, 32'h3);
      chk("R3 pll->slow err", mode_err, 32'd1);
      clr_err();

      // R6 return to fast
      wr(2'd0, 32'h1, 1'b1, 1'b1);
      chk("R6 exit mode", mode_rd, 32'h1);
      chk("R6 exit inactive", pll_active, 32'd0);
      chk("R6 exit clk_sel", clk_sel, 32'd0);

      // R3 request during sync refused, then R6 bypass variant
      wr(2'd0, 32'h7, 1'b1, 1'b1);
      wr(2'd0, 32'h1, 1'b1, 1'b1);
      chk("R3 sync refuse mode", mode_rd, 32'h7);
      chk("R3 sync refuse err", mode_err, 32'd1);
      repeat (8) @(negedge clk_osc);
      chk("R6 bypass clk_sel", clk_sel, 32'd2);
      chk("R6 bypass active", pll_active, 32'd1);
      clr_err();
      wr(2'd0, 32'h1, 1'b1, 1'b1);

      // R7 slow rate
      wr(2'd0, 32'h5, 1'b1, 1'b1);
      chk("R7 clk_sel slow", clk_sel, 32'd3);
      begin
         int ticks = 0;
         for (int k = 0; k < 256; k++) begin
            @(negedge clk_osc);
            if (cpu_clk_en) ticks++;
         end
         chk("R7 enables per 256", ticks, 32'd2);
      end
      wr(2'd0, 32'h1, 1'b1, 1'b1);
      chk("R7 immediate fast", cpu_clk_en, 32'd1);

      // R8 deep-slow gating
      wr(2'd0, 32'h9, 1'b1, 1'b1);
      chk("R8 deep periph", periph_en, 32'h03);
      chk("R8 deep clk_sel", clk_sel, 32'd4);
      wr(2'd0, 32'h1, 1'b1, 1'b1);
      chk("R8 fast periph", periph_en, 32'hFF);

      // R11 sticky and set-wins
      wr(2'd0, 32'h5, 1'b1, 1'b0);
      repeat (5) @(negedge clk_osc);
      chk("R11 sticky", mode_err, 32'd1);
      @(negedge clk_osc);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h5; bus_full = 1'b1;
      irq_dma_off = 1'b0; stat_rd = 1'b1;
      @(negedge clk_osc);
      bus_wr = 1'b0; bus_full = 1'b0; irq_dma_off = 1'b1; stat_rd = 1'b0;
      chk("R11 set wins", mode_err, 32'd1);
      clr_err();
      chk("R11 cleared", mode_err, 32'd0);

      finish_run();
   end
endmodule